// File: doc/BRIEF.md
# Synchronous Serial Converter Control Port

This block is a serial master that talks to an external analog-to-digital converter. A host places one 16-bit control word on the write port. The word carries an eight-bit setup byte for the converter, a five-bit count of shift clocks for the frame, a start flag and a flag that enables a free-running sample clock. When the start flag is set, the block asserts a frame sync and then runs the shift clock for the programmed number of periods. It sends the setup byte most significant bit first and captures the converter's serial output into a 16-bit receive register.

While a frame is in flight the block reports busy. It raises an end-of-frame interrupt when the last shift clock finishes. A host read returns the newest 16 captured bits and clears the interrupt. The shift clock and the sample clock are each derived from the system clock through their own integer divider. A word written without the start flag only updates the sample-clock enable.

Top module: `ssadc_master`

## Requirements
- R1: Write word fields: bits 7:0 setup byte, bits 12:8 frame clock count, bit 13 sample-clock enable, bit 14 start flag; bit 15 has no effect on any output.
- R2: An accepted start with a non-zero count holds sync_o high with sclk_o low for SHIFT_HALF cycles, then drives exactly count sclk_o pulses, each high for SHIFT_HALF and low for SHIFT_HALF system cycles.
- R3: sdo_o presents the setup byte bit 7 first, changes only after a falling edge of sclk_o, and is stable across every rising edge.
- R4: Once the eight setup bits have been sent, sdo_o stays low for the remaining shift clocks of the frame.
- R5: sdi_i is sampled at each rising edge of sclk_o and enters bit 0 of the receive register, older bits moving up; rd_data always shows the newest 16 samples, including samples from earlier frames when the frame is shorter than 16.
- R6: busy_o rises one cycle after the accepted write and stays high for SHIFT_HALF*(2*count+1) cycles; when busy_o is low, sclk_o, sync_o and sdo_o are low.
- R7: eot_irq_o rises in the same cycle that busy_o falls, holds until rd_en is asserted while idle, and is low in the cycle after that read.
- R8: A write with bit 14 clear starts no frame and no sync, and updates the sample-clock enable.
- R9: A write that arrives while busy_o is high is ignored: the frame in flight, its data and the sample-clock enable are unchanged.
- R10: A start with a count of zero starts no frame and raises no interrupt, but still applies the sample-clock enable.
- R11: With the sample-clock enable set, smpclk_o toggles every SMP_HALF cycles (period 2*SMP_HALF); with it clear, smpclk_o is low.
- R12: After reset all outputs are low and rd_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word |
| rd_en | input | 1 | Read strobe; clears the interrupt |
| rd_data | output | 16 | Newest 16 captured bits |
| busy_o | output | 1 | Frame in flight |
| eot_irq_o | output | 1 | End-of-frame interrupt |
| sclk_o | output | 1 | Shift clock to the converter |
| sync_o | output | 1 | Frame sync pulse |
| sdo_o | output | 1 | Serial data to the converter |
| sdi_i | input | 1 | Serial data from the converter |
| smpclk_o | output | 1 | Free-running sample clock |

## Verification
Frames are run with counts of 25, 16, 5 and 1 and with different setup bytes and receive patterns. The long frame shows the zero padding after the setup byte. The frame of 16 fills the receive register exactly. The short frames show that an incomplete byte is truncated and that older samples stay below the new ones. A frame with the reserved bit set, and one that is interrupted by a second write, must match a clean frame bit for bit. Settings-only writes and zero-count starts are told apart from real starts by the absence of busy, sync and interrupt while the sample clock still follows the enable bit.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;
   localparam int CFG_W  = 8;
   localparam int LEN_W  = 5;
   localparam int RX_W   = 16;
   localparam int WORD_W = 16;

   typedef struct packed {
      logic             rsvd;
      logic             go;
      logic             smp_on;
      logic [LEN_W-1:0] clocks;
      logic [CFG_W-1:0] setup;
   } ctrl_word_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SYNC  = 2'd1,
      ST_SHIFT = 2'd2
   } eng_state_t;
endpackage

// File: rtl/ssadc_tick.sv
module ssadc_tick #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic tick
);
   localparam int CW = (HALF < 2) ? 1 : $clog2(HALF);
   localparam logic [CW-1:0] LAST = CW'(HALF - 1);

   generate
      if (HALF < 1) begin : g_bad_half
         $error("ssadc_tick: HALF must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (en) begin
         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end

   assign tick = en && (cnt == LAST);
endmodule

// File: rtl/ssadc_engine.sv
module ssadc_engine
   import ssadc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CFG_W-1:0] setup,
   input  logic [LEN_W-1:0] clocks,
   input  logic             tick,
   input  logic             sdi,
   output logic             busy,
   output logic             sync,
   output logic             sclk,
   output logic             sdo,
   output logic             finish,
   output logic [RX_W-1:0]  rx
);
   eng_state_t       state;
   logic [CFG_W-1:0] tx;
   logic [LEN_W-1:0] left;
   logic             sclk_q;

   assign finish = (state == ST_SHIFT) && tick && sclk_q && (left == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         tx     <= '0;
         left   <= '0;
         sclk_q <= 1'b0;
         rx     <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  tx     <= setup;
                  left   <= clocks;
                  sclk_q <= 1'b0;
                  state  <= ST_SYNC;
               end
            end
            ST_SYNC: begin
               if (tick) state <= ST_SHIFT;
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (!sclk_q) begin
                     sclk_q <= 1'b1;
                     rx     <= {rx[RX_W-2:0], sdi};
                     left   <= left - 1'b1;
                  end else begin
                     sclk_q <= 1'b0;
                     if (left == '0) begin
                        state <= ST_IDLE;
                        tx    <= '0;
                     end else begin
                        tx <= {tx[CFG_W-2:0], 1'b0};
                     end
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state != ST_IDLE);
   assign sync = (state == ST_SYNC);
   assign sclk = sclk_q;
   assign sdo  = busy && tx[CFG_W-1];
endmodule

// File: rtl/ssadc_hostreg.sv
module ssadc_hostreg
   import ssadc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              busy,
   input  logic              finish,
   input  logic              smp_tick,
   output logic              start,
   output logic [CFG_W-1:0]  setup,
   output logic [LEN_W-1:0]  clocks,
   output logic              smp_en,
   output logic              smpclk,
   output logic              irq
);
   ctrl_word_t w;
   logic       accept;

   assign w      = ctrl_word_t'(wr_data);
   assign accept = wr_en && !busy;
   assign start  = accept && w.go && (w.clocks != '0);
   assign setup  = w.setup;
   assign clocks = w.clocks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_en <= 1'b0;
         smpclk <= 1'b0;
         irq    <= 1'b0;
      end else begin
         if (accept) smp_en <= w.smp_on;
         if (!smp_en)       smpclk <= 1'b0;
         else if (smp_tick) smpclk <= ~smpclk;
         if (finish)     irq <= 1'b1;
         else if (rd_en) irq <= 1'b0;
      end
   end
endmodule

// File: rtl/ssadc_master.sv
module ssadc_master
   import ssadc_pkg::*;
#(
   parameter int SHIFT_HALF = 2,
   parameter int SMP_HALF   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [RX_W-1:0]   rd_data,
   output logic              busy_o,
   output logic              eot_irq_o,
   output logic              sclk_o,
   output logic              sync_o,
   output logic              sdo_o,
   input  logic              sdi_i,
   output logic              smpclk_o
);
   generate
      if (SHIFT_HALF < 1 || SMP_HALF < 1) begin : g_bad_div
         $error("ssadc_master: divider halves must be at least 1");
      end
      if ($bits(ctrl_word_t) != WORD_W) begin : g_bad_word
         $error("ssadc_master: control word layout does not fill the port");
      end
   endgenerate

   logic             start, finish, shift_tick, smp_tick, smp_en;
   logic [CFG_W-1:0] setup;
   logic [LEN_W-1:0] clocks;

   ssadc_tick #(.HALF(SHIFT_HALF)) u_shift_div (
      .clk(clk), .rst_n(rst_n), .clr(start), .en(busy_o), .tick(shift_tick)
   );

   ssadc_tick #(.HALF(SMP_HALF)) u_smp_div (
      .clk(clk), .rst_n(rst_n), .clr(!smp_en), .en(smp_en), .tick(smp_tick)
   );

   ssadc_hostreg u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .busy(busy_o), .finish(finish), .smp_tick(smp_tick),
      .start(start), .setup(setup), .clocks(clocks), .smp_en(smp_en),
      .smpclk(smpclk_o), .irq(eot_irq_o)
   );

   ssadc_engine u_eng (
      .clk(clk), .rst_n(rst_n), .start(start), .setup(setup), .clocks(clocks),
      .tick(shift_tick), .sdi(sdi_i), .busy(busy_o), .sync(sync_o),
      .sclk(sclk_o), .sdo(sdo_o), .finish(finish), .rx(rd_data)
   );
endmodule

// File: rtl/ssadc_checker.sv
module ssadc_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [15:0] wr_data,
   input logic        rd_en,
   input logic        busy_o,
   input logic        eot_irq_o,
   input logic        sclk_o,
   input logic        sync_o,
   input logic        sdo_o,
   input logic        smpclk_o,
   input logic        smp_en
);
   p_sync_clk_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sync_o |-> !sclk_o);

   p_sdo_steady_at_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_o) |-> $stable(sdo_o));

   p_idle_lines_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!sclk_o && !sync_o && !sdo_o));

   p_irq_with_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eot_irq_o) |-> $fell(busy_o));

   p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !busy_o) |=> !eot_irq_o);

   p_busy_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy_o) |=> $stable(smp_en));

   p_zero_count_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy_o && wr_data[14] && wr_data[12:8] == 5'd0) |=> !busy_o);

   p_smp_off_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_en |=> !smpclk_o);
endmodule

bind ssadc_master ssadc_checker u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
   .busy_o(busy_o), .eot_irq_o(eot_irq_o), .sclk_o(sclk_o), .sync_o(sync_o),
   .sdo_o(sdo_o), .smpclk_o(smpclk_o), .smp_en(smp_en)
);

// File: tb/tb_ssadc_master.sv
module tb_ssadc_master;
   localparam int SH = 2;
   localparam int MH = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [15:0] rd_data;
   logic        busy_o, eot_irq_o, sclk_o, sync_o, sdo_o, smpclk_o;
   logic        sdi_i;

   int          n_chk = 0;
   int          n_fail = 0;
   int          rise_cnt = 0;
   int          fall_cnt = 0;
   int          fall_base = 0;
   logic [31:0] cur_pat = '0;
   logic [31:0] sdo_cap = '0;
   logic [15:0] rx_model = '0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   ssadc_master #(.SHIFT_HALF(SH), .SMP_HALF(MH)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .busy_o(busy_o),
      .eot_irq_o(eot_irq_o), .sclk_o(sclk_o), .sync_o(sync_o),
      .sdo_o(sdo_o), .sdi_i(sdi_i), .smpclk_o(smpclk_o)
   );

   // converter model: new bit after every falling shift clock
   assign sdi_i = cur_pat[5'(31 - (fall_cnt - fall_base))];
   always @(posedge sclk_o) begin
      rise_cnt = rise_cnt + 1;
      sdo_cap  = {sdo_cap[30:0], sdo_o};
   end
   always @(negedge sclk_o) fall_cnt = fall_cnt + 1;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   task automatic t_reset();
      chk("R12 rd_data", 32'(rd_data), 0);
      chk("R12 busy", 32'(busy_o), 0);
      chk("R12 irq", 32'(eot_irq_o), 0);
      chk("R12 lines", {28'd0, sclk_o, sync_o, sdo_o, smpclk_o}, 0);
   endtask

   // one frame: optional second write at cycle poke_at while busy (R9)
   task automatic t_frame(string tag, logic [7:0] cfg, int len, logic [31:0] pat,
                          logic rsv, int poke_at, logic [15:0] poke);
      int busy_c = 0;
      int sync_c = 0;
      int rise0;
      logic [31:0] exp_sdo = '0;
      logic [31:0] mask;
      cur_pat   = pat;
      fall_base = fall_cnt;
      rise0     = rise_cnt;
      @(negedge clk);
      wr_data = {rsv, 1'b1, 1'b0, 5'(len), cfg};
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      for (int cyc = 0; busy_o && cyc < 4000; cyc++) begin
         busy_c++;
         if (sync_o) sync_c++;
         if (cyc == poke_at) begin
            wr_data = poke;
            wr_en   = 1'b1;
         end else begin
            wr_en = 1'b0;
         end
         @(negedge clk);
      end
      wr_en = 1'b0;
      chk({tag, " R6 busy cycles"}, busy_c, SH * (2 * len + 1));
      chk({tag, " R2 sync cycles"}, sync_c, SH);
      chk({tag, " R2 shift clocks"}, rise_cnt - rise0, len);
      for (int i = 0; i < len; i++)
         exp_sdo = {exp_sdo[30:0], (i < 8) ? cfg[7 - i] : 1'b0};
      mask = (32'd1 << len) - 1;
      chk({tag, " R3 R4 serial out"}, sdo_cap & mask, exp_sdo);
      chk({tag, " R7 irq set"}, 32'(eot_irq_o), 1);
      for (int i = 0; i < len; i++)
         rx_model = {rx_model[14:0], pat[31 - i]};
      repeat (3) @(negedge clk);
      chk({tag, " R7 irq held"}, 32'(eot_irq_o), 1);
      rd_en = 1'b1;
      chk({tag, " R5 read data"}, 32'(rd_data), 32'(rx_model));
      @(negedge clk);
      rd_en = 1'b0;
      chk({tag, " R7 irq cleared"}, 32'(eot_irq_o), 0);
      chk({tag, " R9 sample clock untouched"}, 32'(smpclk_o), 0);
   endtask

   // settings-only write and sample clock (R8, R11)
   task automatic t_settings();
      int rises = 0;
      int first = -1;
      int period = 0;
      logic prev;
      int r0 = rise_cnt;
      @(negedge clk);
      wr_data = 16'h2955;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      prev  = smpclk_o;
      for (int c = 0; c < 40; c++) begin
         if (busy_o || sync_o) rises = 100;
         @(negedge clk);
         if (smpclk_o && !prev) begin
            if (first < 0) first = c;
            else if (period == 0) period = c - first;
         end
         prev = smpclk_o;
      end
      chk("R8 no frame", 32'(rises), 0);
      chk("R8 no shift clocks", rise_cnt - r0, 0);
      chk("R8 no irq", 32'(eot_irq_o), 0);
      chk("R11 sample period", period, 2 * MH);
      @(negedge clk);
      wr_data = 16'h0000;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
      rises = 0;
      for (int c = 0; c < 20; c++) begin
         if (smpclk_o) rises++;
         @(negedge clk);
      end
      chk("R11 sample clock off", 32'(rises), 0);
   endtask

   // start with zero count (R10)
   task automatic t_zero_len();
      int hi = 0;
      int bz = 0;
      int r0 = rise_cnt;
      @(negedge clk);
      wr_data = 16'h60A5;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      for (int c = 0; c < 30; c++) begin
         if (busy_o || sync_o) bz++;
         if (smpclk_o) hi++;
         @(negedge clk);
      end
      chk("R10 no busy", 32'(bz), 0);
      chk("R10 no clocks", rise_cnt - r0, 0);
      chk("R10 no irq", 32'(eot_irq_o), 0);
      chk("R10 enable applied", 32'(hi > 0), 1);
      @(negedge clk);
      wr_data = 16'h0000;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_frame("f25", 8'hA5, 25, 32'h9C3B_71E5, 1'b0, -1, 16'h0);
      t_frame("f16", 8'hFF, 16, 32'h1234_5678, 1'b0, -1, 16'h0);
      t_frame("f5",  8'h3C, 5,  32'hD800_0000, 1'b0, -1, 16'h0);
      t_frame("f1",  8'h80, 1,  32'h8000_0000, 1'b0, -1, 16'h0);
      t_frame("R1 rsvd", 8'h5A, 12, 32'hF0F0_F0F0, 1'b1, -1, 16'h0);
      t_frame("R9 busy wr", 8'h96, 12, 32'hAAAA_5555, 1'b0, 9, 16'h7F00);
      t_settings();
      t_zero_len();
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
      end
   end
endmodule